// File: doc/BRIEF.md
# SMRAM Access Gate

This block sits between the bus masters and the memory controller and chooses, for each request, whether it reaches the SMRAM window or falls through to ordinary memory. The window covers the upper 32 KiB half of a 64 KiB region whose start is held in a base register. After reset the base is 0x30000, so the window covers 0x38000–0x3FFFF. The mode-switch logic reloads the base, and the window then moves with it.

A request that hits the window is routed to SMRAM only when two conditions hold. It must come from the CPU, and either the CPU must be in system management mode or boot firmware must have opened the window by software. Any other request that hits the window is refused and forwarded to ordinary memory at the same address. Firmware can set a sticky lock that stops the open bit from being set again until the next reset.

The decode is combinational. The routing decision and the forwarded address come out of registers one clock after the request.

Top module: `smram_gate`

## Requirements
- R1: After reset the base register holds 0x30000, the open and lock bits are clear, and all select and deny outputs and `addr_o` are low. The first window is therefore 0x38000–0x3FFFF.
- R2: A request hits the window when `base + 0x8000 <= addr <= base + 0xFFFF`, with both bounds inclusive. An address one below or one above the window misses.
- R3: A request whose master identifier is not the CPU (CPU = 0) never asserts `smram_sel_o`, whatever the mode and open state.
- R4: A CPU request that hits the window asserts `smram_sel_o` only if `smm_active_i` or the open bit was set in the request cycle. Otherwise it asserts `deny_o`.
- R5: Every valid request that is not routed to SMRAM asserts `normal_sel_o`. `addr_o` always equals the request address of the previous cycle, and `smram_sel_o` and `normal_sel_o` are never high together.
- R6: Outputs follow the request by exactly one cycle. In a cycle with no valid request, all three selects are low in the next cycle.
- R7: A base load whose data has bits [14:0] all zero replaces the base, and the new base applies to requests from the next cycle. A load with any of those bits set leaves the base unchanged.
- R8: `open_set_i` sets the open bit and `open_clr_i` clears it. When both are asserted together, the clear wins.
- R9: Once `lock_set_i` has been seen, `open_set_i` has no effect until reset. The lock does not by itself clear an open bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request byte address |
| req_master_i | input | 2 | Master identifier, 0 = CPU |
| smm_active_i | input | 1 | CPU is in system management mode |
| base_load_i | input | 1 | Load base register |
| base_data_i | input | 32 | New base value |
| open_set_i | input | 1 | Set the software open bit |
| open_clr_i | input | 1 | Clear the software open bit |
| lock_set_i | input | 1 | Set the sticky lock |
| smram_sel_o | output | 1 | Request routed to SMRAM |
| normal_sel_o | output | 1 | Request routed to ordinary memory |
| deny_o | output | 1 | Request hit the window but was refused |
| addr_o | output | 32 | Forwarded address |

## Verification
On every cycle the assertions check four things:
- a non-CPU master never obtains SMRAM;
- any grant was backed by SMM or the open bit one cycle earlier;
- an idle cycle yields idle outputs, and the address is forwarded with one cycle of delay;
- a misaligned base load leaves the base alone, a locked-and-closed gate stays closed, and a clear always closes it.

Only the bench scenarios can show the rest: exact window bounds around both the default and a relocated base, the clear-over-set priority, the lock being released by reset, and correct deny and fall-through routing across mixed masters and modes. These are checked against a behavioural reference model every clock.

// File: rtl/smram_gate_pkg.sv
package smram_gate_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned MASTER_W = 2;
  localparam int unsigned ALIGN_W  = 15;  // 32 KiB granule

  typedef struct packed {
    logic smram;
    logic normal;
    logic deny;
  } route_t;
endpackage

// File: rtl/smram_base_reg.sv
module smram_base_reg #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ALIGN_W  = 15,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h0003_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_data_i,
  output logic [ADDR_W-1:0] base_o
);
  logic aligned;
  assign aligned = (load_data_i[ALIGN_W-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                base_o <= BASE_RST;
    else if (load_i && aligned) base_o <= load_data_i;
  end

  AST_BASE_MISALIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_data_i[ALIGN_W-1:0] != '0) |=> $stable(base_o)); // R7
  AST_BASE_ALIGNED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_data_i[ALIGN_W-1:0] == '0) |=> base_o == $past(load_data_i)); // R7
endmodule

// File: rtl/smram_open_ctrl.sv
module smram_open_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_set_i,
  input  logic open_clr_i,
  input  logic lock_set_i,
  output logic open_o,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      if (open_clr_i)                 open_o <= 1'b0;
      else if (open_set_i && !lock_o) open_o <= 1'b1;
      if (lock_set_i) lock_o <= 1'b1;
    end
  end

  AST_LOCK_HOLDS_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !open_o) |=> !open_o); // R9
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_clr_i |=> !open_o); // R8
endmodule

// File: rtl/smram_window_dec.sv
module smram_window_dec
  import smram_gate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ALIGN_W  = 15,
  parameter int unsigned MASTER_W = 2,
  parameter int unsigned CPU_ID   = 0
) (
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                valid_i,
  input  logic [MASTER_W-1:0] master_i,
  input  logic                smm_i,
  input  logic                open_i,
  output route_t              route_o
);
  localparam int unsigned PAGE_W = ADDR_W - ALIGN_W;

  logic [PAGE_W-1:0] win_page;
  logic              hit, is_cpu, grant;

  // window is the granule right above the base
  assign win_page = base_i[ADDR_W-1:ALIGN_W] + PAGE_W'(1);
  assign hit      = valid_i && (addr_i[ADDR_W-1:ALIGN_W] == win_page);
  assign is_cpu   = (master_i == MASTER_W'(CPU_ID));
  assign grant    = hit && is_cpu && (smm_i || open_i);

  always_comb begin
    route_o.smram  = grant;
    route_o.deny   = hit && !grant;
    route_o.normal = valid_i && !grant;
  end
endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_gate_pkg::*;
#(
  parameter int unsigned CPU_ID = 0,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h0003_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [MASTER_W-1:0] req_master_i,
  input  logic                smm_active_i,
  input  logic                base_load_i,
  input  logic [ADDR_W-1:0]   base_data_i,
  input  logic                open_set_i,
  input  logic                open_clr_i,
  input  logic                lock_set_i,
  output logic                smram_sel_o,
  output logic                normal_sel_o,
  output logic                deny_o,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic              open_q, lock_q;
  route_t            route_d, route_q;

  smram_base_reg #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .BASE_RST(BASE_RST)) u_base (
    .clk_i, .rst_ni,
    .load_i(base_load_i), .load_data_i(base_data_i), .base_o(base_q)
  );

  smram_open_ctrl u_open (
    .clk_i, .rst_ni,
    .open_set_i, .open_clr_i, .lock_set_i,
    .open_o(open_q), .lock_o(lock_q)
  );

  smram_window_dec #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .MASTER_W(MASTER_W),
                     .CPU_ID(CPU_ID)) u_dec (
    .base_i(base_q), .addr_i(req_addr_i), .valid_i(req_valid_i),
    .master_i(req_master_i), .smm_i(smm_active_i), .open_i(open_q),
    .route_o(route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      addr_o  <= '0;
    end else begin
      route_q <= route_d;
      addr_o  <= req_addr_i;
    end
  end

  assign smram_sel_o  = route_q.smram;
  assign normal_sel_o = route_q.normal;
  assign deny_o       = route_q.deny;

  logic unused_lock;
  assign unused_lock = lock_q;

  AST_DMA_NO_SMRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_master_i != MASTER_W'(CPU_ID)) |=> !smram_sel_o); // R3
  AST_GRANT_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_sel_o |-> ($past(smm_active_i) || $past(open_q))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!smram_sel_o && !normal_sel_o && !deny_o)); // R6
  AST_ADDR_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> addr_o == $past(req_addr_i)); // R5
  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smram_sel_o && normal_sel_o)); // R5
endmodule

// File: tb/smram_gate_test.sv
module smram_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_master = '0;
  logic        smm = 1'b0;
  logic        base_load = 1'b0;
  logic [31:0] base_data = '0;
  logic        open_set = 1'b0, open_clr = 1'b0, lock_set = 1'b0;
  logic        smram_sel, normal_sel, deny;
  logic [31:0] addr_out;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  smram_gate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_master_i(req_master),
    .smm_active_i(smm), .base_load_i(base_load), .base_data_i(base_data),
    .open_set_i(open_set), .open_clr_i(open_clr), .lock_set_i(lock_set),
    .smram_sel_o(smram_sel), .normal_sel_o(normal_sel), .deny_o(deny),
    .addr_o(addr_out)
  );

  // reference model
  longint m_base;
  bit m_open, m_lock, e_sel, e_norm, e_deny;
  logic [31:0] e_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 32'h30000; m_open = 0; m_lock = 0;
      e_sel = 0; e_norm = 0; e_deny = 0; e_addr = 0;
    end else begin
      longint a, lo, hi;
      bit hit, ok;
      a  = req_addr;
      lo = m_base + 32'h8000;
      hi = m_base + 32'hFFFF;
      hit = req_valid && a >= lo && a <= hi;
      ok  = hit && req_master == 0 && (smm || m_open);
      e_sel = ok; e_deny = hit && !ok; e_norm = req_valid && !ok;
      e_addr = req_addr;
      if (base_load && base_data % 32768 == 0) m_base = base_data;
      if (open_clr) m_open = 0;
      else if (open_set && !m_lock) m_open = 1;
      if (lock_set) m_lock = 1;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(smram_sel == e_sel,  "smram_sel",  smram_sel,  e_sel);
    chk(normal_sel == e_norm, "normal_sel", normal_sel, e_norm);
    chk(deny == e_deny,      "deny",       deny,       e_deny);
    chk(addr_out == e_addr,  "addr",       addr_out,   e_addr);
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic rq(logic [31:0] a, logic [1:0] m, bit s);
    req_valid = 1; req_addr = a; req_master = m; smm = s;
    tick();
    req_valid = 0; smm = 0;
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tag = "R1";
    tick(); tick();
    rst_n = 1;
    tick();
    rq(32'h38000, 0, 1);              // R1 default window
    rq(32'h3FFFF, 0, 1);
    tag = "R2";
    rq(32'h37FFF, 0, 1);
    rq(32'h38000, 0, 1);
    rq(32'h3FFFF, 0, 1);
    rq(32'h40000, 0, 1);
    rq(32'h30000, 0, 1);
    tag = "R3";
    for (int m = 1; m < 4; m++) rq(32'h38010, 2'(m), 1);
    open_set = 1; tick(); open_set = 0;
    for (int m = 1; m < 4; m++) rq(32'h3C000, 2'(m), 0);
    open_clr = 1; tick(); open_clr = 0;
    tag = "R4";
    rq(32'h38100, 0, 0);
    rq(32'h38100, 0, 1);
    tag = "R6";
    tick(); tick();
    tag = "R8";
    open_set = 1; rq(32'h38200, 0, 0); open_set = 0;  // old state applies
    rq(32'h38200, 0, 0);
    open_set = 1; open_clr = 1; tick(); open_set = 0; open_clr = 0;
    rq(32'h38200, 0, 0);
    tag = "R9";
    open_set = 1; tick(); open_set = 0;
    lock_set = 1; tick(); lock_set = 0;
    rq(32'h38300, 0, 0);              // still open
    open_clr = 1; tick(); open_clr = 0;
    open_set = 1; tick(); open_set = 0;
    rq(32'h38300, 0, 0);              // stays closed
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    open_set = 1; tick(); open_set = 0;
    rq(32'h38300, 0, 0);              // lock gone after reset
    open_clr = 1; tick(); open_clr = 0;
    tag = "R7";
    base_data = 32'h100000; base_load = 1; rq(32'h38000, 0, 1); base_load = 0;
    rq(32'h38000, 0, 1);
    rq(32'h107FFF, 0, 1);
    rq(32'h108000, 0, 1);
    rq(32'h10FFFF, 0, 1);
    rq(32'h110000, 0, 1);
    base_data = 32'h204000; base_load = 1; tick(); base_load = 0;
    rq(32'h10C000, 0, 1);
    rq(32'h20C000, 0, 1);
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      req_valid  = 1'($urandom);
      req_addr   = 32'h100000 + ($urandom % 32'h14000);
      req_master = 2'($urandom);
      smm        = 1'($urandom);
      open_set   = ($urandom % 8) == 0;
      open_clr   = ($urandom % 8) == 0;
      tick();
    end
    req_valid = 0; open_set = 0; open_clr = 0; smm = 0;
    tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule